// File: doc/BRIEF.md
# Lockstep Mealy Machine Equivalence Monitor

This block runs two small Mealy machines side by side on one serial input stream and compares their outputs on every accepted input bit. One machine is a three-state reference. The other is a two-state implementation that is meant to behave identically once the reference's redundant state is merged. A fault-select input can deliberately break the implementation, which lets a bench confirm that the monitor catches each kind of divergence.

The monitor treats the two machines as one product machine, and its state is the pair (reference state, implementation state), starting at (0,0). Each accepted input either advances both machines together, when their outputs agree, or stops the monitor, when they disagree. At the first disagreement the monitor raises a sticky error, freezes the pair state at the pair where the outputs differed, and keeps the input bits accepted since reset. Those bits form a distinguishing sequence that can be replayed on models of the two machines. If no accepted input ever gives differing outputs, no error is raised and the two machines match on every input sequence that was applied.

Top module: `fsm_equiv_monitor`

## Requirements
- R1: After a synchronous reset, pairState is 0 (both machines in state 0), errSticky is 0, stepEqual is 1, traceLen is 0, traceBits is 0 and traceOverflow is 0.
- R2: The reference machine (pairState[2:1], states 0, 1, 2) behaves as follows, written as state/input -> next state, output: 0/0->0,0; 0/1->1,0; 1/0->2,1; 1/1->1,0; 2/0->0,0; 2/1->1,0.
- R3: With faultSel 0, the implementation machine (pairState[0], states 0, 1) behaves as follows: 0/0->0,0; 0/1->1,0; 1/0->0,1; 1/1->1,0.
- R4: An input presented with inValid low changes no output.
- R5: On a clock edge where inValid is high and no error is held, stepEqual becomes 1 if the two machine outputs for the current pair state and inBit are equal, and 0 otherwise; the value holds until the next accepted input.
- R6: When an accepted input gives equal outputs, both machines take their transitions on that edge; when the outputs differ, errSticky becomes 1 and pairState keeps the pair where the difference arose.
- R7: Once errSticky is 1, further inputs change neither pairState, stepEqual, traceBits, traceLen nor traceOverflow until reset.
- R8: The k-th accepted input since reset (k counted from 0) is stored in traceBits[k] and traceLen counts the stored inputs; the input that caused an error is stored too, so traceLen at an error equals the length of the distinguishing sequence.
- R9: traceBits holds the first 16 accepted inputs; a 17th or later accepted input sets traceOverflow, leaves traceBits unchanged and holds traceLen at 16.
- R10: faultSel 1 makes the implementation output 1 in state 1 on input 1; faultSel 2 sends the implementation from state 0 to state 1 on input 0; faultSel 3 keeps the implementation in state 1 on input 0. Each produces an error whose captured sequence, replayed on both machine tables from (0,0), first gives differing outputs on its last bit.
- R11: With faultSel 0, no input sequence sets errSticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inBit | input | 1 | Serial input bit fed to both machines |
| inValid | input | 1 | Marks inBit as an input to be applied this cycle |
| faultSel | input | 2 | 0 for the equivalent implementation, 1 to 3 for one injected fault |
| stepEqual | output | 1 | Result of the output comparison for the last accepted input |
| errSticky | output | 1 | Set at the first output mismatch, held until reset |
| pairState | output | 3 | Reference state in bits 2:1, implementation state in bit 0 |
| traceBits | output | 16 | Accepted inputs, bit k is the k-th input since reset |
| traceLen | output | 5 | Number of inputs stored in traceBits |
| traceOverflow | output | 1 | More than 16 inputs were accepted without an error |

## Verification
The functions that share a cycle are the detection of a mismatch and the recording of the input that caused it: on the erring edge the error is raised, the pair state is held instead of advanced, and the last trace bit and length are written all at once. Every input sequence up to six bits is applied under each fault setting, and after each accepted bit the pair state, equality bit, error flag and trace length are compared with a bench model of both tables. At each error the captured sequence is replayed on that model, which must show equal outputs on every bit except the last. Separate scenarios push past sixteen inputs, hold inValid low, and keep driving after an error to show that nothing moves.

// File: rtl/fsm_equiv_pkg.sv
package fsm_equiv_pkg;

  // Reference machine state encoding (three states, 0 and 2 are equivalent)
  typedef enum logic [1:0] {
    REF_S0 = 2'd0,
    REF_S1 = 2'd1,
    REF_S2 = 2'd2
  } refState_t;

  // Implementation machine state encoding (two states)
  typedef enum logic {
    IMP_S0 = 1'b0,
    IMP_S1 = 1'b1
  } impState_t;

  // Fault codes for the implementation machine
  localparam logic [1:0] FAULT_NONE    = 2'd0;
  localparam logic [1:0] FAULT_OUT11   = 2'd1;
  localparam logic [1:0] FAULT_GO_S1   = 2'd2;
  localparam logic [1:0] FAULT_STAY_S1 = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;  // input taken this edge
    logic match;   // machine outputs agree for this input
  } ctrlStrobe_t;

endpackage

// File: rtl/fsm_ref_machine.sv
module fsm_ref_machine
  import fsm_equiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      advance,
  input  logic      inBit,
  output refState_t state,
  output logic      outBit
);

  refState_t nextState;

  always_comb begin
    nextState = REF_S0;
    outBit    = 1'b0;
    unique case (state)
      REF_S0: begin
        nextState = inBit ? REF_S1 : REF_S0;
        outBit    = 1'b0;
      end
      REF_S1: begin
        nextState = inBit ? REF_S1 : REF_S2;
        outBit    = ~inBit;
      end
      REF_S2: begin
        nextState = inBit ? REF_S1 : REF_S0;
        outBit    = 1'b0;
      end
      default: begin
        nextState = REF_S0;
        outBit    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          state <= REF_S0;
    else if (advance) state <= nextState;
  end

  // R2: the unused encoding is never entered
  a_r2_legal_state: assert property (@(posedge clk) disable iff (rst)
    state != refState_t'(2'd3));

  // R2: input 1 always lands in state 1
  a_r2_one_goes_s1: assert property (@(posedge clk) disable iff (rst)
    (advance && inBit) |=> (state == REF_S1));

endmodule

// File: rtl/fsm_impl_machine.sv
module fsm_impl_machine
  import fsm_equiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       advance,
  input  logic       inBit,
  input  logic [1:0] faultSel,
  output impState_t  state,
  output logic       outBit
);

  impState_t nextState;

  always_comb begin
    nextState = IMP_S0;
    outBit    = 1'b0;
    unique case (state)
      IMP_S0: begin
        if (inBit)                         nextState = IMP_S1;
        else if (faultSel == FAULT_GO_S1)  nextState = IMP_S1;
        else                               nextState = IMP_S0;
        outBit = 1'b0;
      end
      IMP_S1: begin
        if (inBit) begin
          nextState = IMP_S1;
          outBit    = (faultSel == FAULT_OUT11);
        end else begin
          nextState = (faultSel == FAULT_STAY_S1) ? IMP_S1 : IMP_S0;
          outBit    = 1'b1;
        end
      end
      default: begin
        nextState = IMP_S0;
        outBit    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          state <= IMP_S0;
    else if (advance) state <= nextState;
  end

  // R3: without a fault, state 0 with input 0 stays in state 0
  a_r3_s0_hold: assert property (@(posedge clk) disable iff (rst)
    (advance && !inBit && state == IMP_S0 && faultSel == FAULT_NONE)
      |=> (state == IMP_S0));

endmodule

// File: rtl/fsm_equiv_ctrl.sv
module fsm_equiv_ctrl
  import fsm_equiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        refOut,
  input  logic        impOut,
  output ctrlStrobe_t strobe,
  output logic        stepAdvance,
  output logic        errSticky
);

  always_comb begin
    strobe.accept = inValid && !errSticky;
    strobe.match  = (refOut == impOut);
    stepAdvance   = strobe.accept && strobe.match;
  end

  always_ff @(posedge clk) begin
    if (rst)                                errSticky <= 1'b0;
    else if (strobe.accept && !strobe.match) errSticky <= 1'b1;
  end

  // R6: a mismatching accepted input raises the error
  a_r6_raise: assert property (@(posedge clk) disable iff (rst)
    (inValid && !errSticky && refOut != impOut) |=> errSticky);

  // R7: the error is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    errSticky |=> errSticky);

endmodule

// File: rtl/fsm_equiv_datapath.sv
module fsm_equiv_datapath
  import fsm_equiv_pkg::*;
#(
  parameter int TRACE_DEPTH = 16,
  localparam int LEN_W = $clog2(TRACE_DEPTH + 1),
  localparam int IDX_W = (TRACE_DEPTH > 1) ? $clog2(TRACE_DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrlStrobe_t            strobe,
  input  logic                   inBit,
  output logic                   stepEqual,
  output logic [TRACE_DEPTH-1:0] traceBits,
  output logic [LEN_W-1:0]       traceLen,
  output logic                   traceOverflow
);

  localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(TRACE_DEPTH);

  logic              hasRoom;
  logic [IDX_W-1:0]  wrIdx;

  assign hasRoom = (traceLen < LEN_FULL);
  assign wrIdx   = traceLen[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stepEqual     <= 1'b1;
      traceBits     <= '0;
      traceLen      <= '0;
      traceOverflow <= 1'b0;
    end else if (strobe.accept) begin
      stepEqual <= strobe.match;
      if (hasRoom) begin
        traceBits[wrIdx] <= inBit;
        traceLen         <= traceLen + LEN_W'(1);
      end else begin
        traceOverflow <= 1'b1;
      end
    end
  end

  // R9: length never passes the buffer depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    traceLen <= LEN_FULL);

  // R9: overflow only with a full buffer
  a_r9_ovf_full: assert property (@(posedge clk) disable iff (rst)
    traceOverflow |-> (traceLen == LEN_FULL));

  // R4: no accepted input leaves the trace untouched
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.accept |=> ($stable(traceLen) && $stable(traceBits)));

endmodule

// File: rtl/fsm_equiv_monitor.sv
module fsm_equiv_monitor
  import fsm_equiv_pkg::*;
#(
  parameter int TRACE_DEPTH = 16,
  localparam int LEN_W = $clog2(TRACE_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inBit,
  input  logic                   inValid,
  input  logic [1:0]             faultSel,
  output logic                   stepEqual,
  output logic                   errSticky,
  output logic [2:0]             pairState,
  output logic [TRACE_DEPTH-1:0] traceBits,
  output logic [LEN_W-1:0]       traceLen,
  output logic                   traceOverflow
);

  ctrlStrobe_t strobe;
  logic        stepAdvance;
  logic        refOut;
  logic        impOut;
  refState_t   refState;
  impState_t   impState;

  fsm_ref_machine u_ref (
    .clk     (clk),
    .rst     (rst),
    .advance (stepAdvance),
    .inBit   (inBit),
    .state   (refState),
    .outBit  (refOut)
  );

  fsm_impl_machine u_imp (
    .clk      (clk),
    .rst      (rst),
    .advance  (stepAdvance),
    .inBit    (inBit),
    .faultSel (faultSel),
    .state    (impState),
    .outBit   (impOut)
  );

  fsm_equiv_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .refOut      (refOut),
    .impOut      (impOut),
    .strobe      (strobe),
    .stepAdvance (stepAdvance),
    .errSticky   (errSticky)
  );

  fsm_equiv_datapath #(.TRACE_DEPTH(TRACE_DEPTH)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .inBit         (inBit),
    .stepEqual     (stepEqual),
    .traceBits     (traceBits),
    .traceLen      (traceLen),
    .traceOverflow (traceOverflow)
  );

  assign pairState = {refState, impState};

  // R7: after an error the pair state is frozen
  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    errSticky |=> $stable(pairState));

  // R6: equality bit and error flag never disagree after an error
  a_r6_eq_low: assert property (@(posedge clk) disable iff (rst)
    $rose(errSticky) |-> !stepEqual);

endmodule

// File: tb/fsm_equiv_monitor_tb.sv
module fsm_equiv_monitor_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        inBit;
  logic        inValid;
  logic [1:0]  faultSel;
  logic        stepEqual;
  logic        errSticky;
  logic [2:0]  pairState;
  logic [15:0] traceBits;
  logic [4:0]  traceLen;
  logic        traceOverflow;

  int nChecks = 0;
  int nFails  = 0;

  // bench model state
  int  mRef, mImp, mLen;
  bit  mErr, mEq, mOvf;
  logic [15:0] mTrace;

  always #5 clk = ~clk;

  fsm_equiv_monitor u_dut (
    .clk(clk), .rst(rst), .inBit(inBit), .inValid(inValid),
    .faultSel(faultSel), .stepEqual(stepEqual), .errSticky(errSticky),
    .pairState(pairState), .traceBits(traceBits), .traceLen(traceLen),
    .traceOverflow(traceOverflow)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference table from R2: returns {next, out}
  function automatic void refModel(input int s, input bit x, output int ns, output bit o);
    case (s)
      0: begin ns = x ? 1 : 0; o = 0; end
      1: begin ns = x ? 1 : 2; o = !x; end
      default: begin ns = x ? 1 : 0; o = 0; end
    endcase
  endfunction

  // implementation table from R3 and R10
  function automatic void impModel(input int s, input bit x, input int f, output int ns, output bit o);
    if (s == 0) begin
      ns = (x || f == 2) ? 1 : 0; o = 0;
    end else if (x) begin
      ns = 1; o = (f == 1);
    end else begin
      ns = (f == 3) ? 1 : 0; o = 1;
    end
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; inBit = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    mRef = 0; mImp = 0; mLen = 0; mErr = 0; mEq = 1; mOvf = 0; mTrace = '0;
  endtask

  task automatic step(input bit x);
    int rn, in_;
    bit ro, io;
    @(negedge clk);
    inBit = x; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    if (!mErr) begin
      refModel(mRef, x, rn, ro);
      impModel(mImp, x, int'(faultSel), in_, io);
      mEq = (ro == io);
      if (mEq) begin mRef = rn; mImp = in_; end
      else mErr = 1;
      if (mLen < 16) begin mTrace[mLen] = x; mLen++; end
      else mOvf = 1;
    end
  endtask

  task automatic checkModel(input string tag);
    check({tag, " R2 R3 R6 pairState"}, int'(pairState), mRef * 2 + mImp);
    check({tag, " R5 stepEqual"}, int'(stepEqual), int'(mEq));
    check({tag, " R6 errSticky"}, int'(errSticky), int'(mErr));
    check({tag, " R8 traceLen"}, int'(traceLen), mLen);
  endtask

  task automatic testReset();
    faultSel = 2'd0;
    doReset();
    check("R1 pairState", int'(pairState), 0);
    check("R1 errSticky", int'(errSticky), 0);
    check("R1 stepEqual", int'(stepEqual), 1);
    check("R1 traceLen", int'(traceLen), 0);
    check("R1 traceBits", int'(traceBits), 0);
    check("R1 traceOverflow", int'(traceOverflow), 0);
  endtask

  // replay captured trace on the tables: equal until last bit, differ there
  task automatic replayTrace(input int f);
    int rs = 0, is_ = 0, rn, in_, firstMis = -1;
    bit ro, io;
    for (int k = 0; k < int'(traceLen); k++) begin
      refModel(rs, traceBits[k], rn, ro);
      impModel(is_, traceBits[k], f, in_, io);
      if (ro != io && firstMis < 0) firstMis = k;
      rs = rn; is_ = in_;
    end
    check("R10 replay first mismatch at last bit", firstMis, int'(traceLen) - 1);
  endtask

  task automatic testExhaustive(input int f, input int maxLen);
    bit sawErr = 0;
    faultSel = 2'(f);
    for (int len = 1; len <= maxLen; len++) begin
      for (int v = 0; v < (1 << len); v++) begin
        doReset();
        for (int k = 0; k < len; k++) begin
          step(v[k]);
          checkModel("seq");
        end
        if (errSticky) begin
          sawErr = 1;
          check("R8 trace matches applied inputs", int'(traceBits), int'(mTrace));
          replayTrace(f);
        end
      end
    end
    if (f == 0) check("R11 no error without fault", int'(sawErr), 0);
    else        check("R10 fault detected", int'(sawErr), 1);
  endtask

  task automatic testFixedFault();
    // fault 1: inputs 1,1 give mismatch at (1,1)
    faultSel = 2'd1;
    doReset();
    step(1); step(1);
    check("R10 fault1 errSticky", int'(errSticky), 1);
    check("R10 fault1 len", int'(traceLen), 2);
    check("R6 fault1 frozen pair", int'(pairState), 3);
    // fault 3: inputs 1,0,0
    faultSel = 2'd3;
    doReset();
    step(1); step(0);
    check("R10 fault3 no error yet", int'(errSticky), 0);
    step(0);
    check("R10 fault3 errSticky", int'(errSticky), 1);
    check("R10 fault3 traceBits", int'(traceBits), 1);
    check("R10 fault3 len", int'(traceLen), 3);
  endtask

  task automatic testIgnoredAfterError();
    logic [2:0]  p;
    logic [15:0] tb;
    faultSel = 2'd2;
    doReset();
    step(0); step(0);
    check("R7 error raised", int'(errSticky), 1);
    p = pairState; tb = traceBits;
    step(1); step(1); step(0);
    check("R7 pairState frozen", int'(pairState), int'(p));
    check("R7 traceBits frozen", int'(traceBits), int'(tb));
    check("R7 traceLen frozen", int'(traceLen), 2);
    check("R7 stepEqual frozen", int'(stepEqual), 0);
    check("R7 overflow untouched", int'(traceOverflow), 0);
  endtask

  task automatic testInvalidIgnored();
    faultSel = 2'd0;
    doReset();
    step(1);
    @(negedge clk);
    inBit = 1'b0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 pairState hold", int'(pairState), 2 * 1 + 1);
    check("R4 traceLen hold", int'(traceLen), 1);
    check("R4 stepEqual hold", int'(stepEqual), 1);
  endtask

  task automatic testOverflow();
    logic [15:0] pat = 16'hB5A3;
    faultSel = 2'd0;
    doReset();
    for (int k = 0; k < 16; k++) step(pat[k]);
    check("R9 full no overflow", int'(traceOverflow), 0);
    check("R9 len 16", int'(traceLen), 16);
    step(~pat[0]);
    check("R9 overflow set", int'(traceOverflow), 1);
    check("R9 len held", int'(traceLen), 16);
    check("R9 first 16 kept", int'(traceBits), int'(pat));
    checkModel("ovf");
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; inBit = 1'b0; faultSel = 2'd0;
    testReset();
    testInvalidIgnored();
    testFixedFault();
    testIgnoredAfterError();
    testOverflow();
    for (int f = 0; f < 4; f++) testExhaustive(f, 6);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule